// File: doc/BRIEF.md
# Paged 32-bit register bridge for a 16-bit management port

This block sits behind an already decoded management-port slave. Each cycle it may receive one register access strobe carrying a PHY address, a 5-bit register number, a direction and 16 bits of write data. The bridge answers at one PHY address only. It uses that address's register space to reach a 32-bit internal register bus whose address is 16 bits wide and always word aligned.

Register 31 is a page register. It holds internal address bits 15:6. Registers 0 to 15 pick the word inside the page (address bits 5:2) and carry the low half of the data. Register 16 carries the high half. A 32-bit write is a page write, a low-half write and then a high-half write. The low half waits in a buffer until the high half arrives, and only then is one bus write issued. A 32-bit read is a page write, a low-half read and then a high-half read. The low-half read performs the bus read, and the upper half is kept for the high-half read that follows.

Bus requests are combinational from the strobe and complete in the same cycle. The slave's read data is sampled at that clock edge. Every read strobe is answered by a registered `rsp_valid` pulse one cycle later.

Top module: `mdio_page_bridge`

## Requirements
- R1: Synchronous reset clears the page register, the low-half buffer and the high-half latch to zero and deasserts `rsp_valid`. The first reads after reset therefore return 0x0000 for register 31 and register 16.
- R2: A strobe whose PHY address differs from `BRIDGE_PHY` (default 31) raises no bus request and changes no state. If it is a read, it is answered with 0xFFFF.
- R3: A write to register 31 loads `wdata[9:0]` into the page register. A read of register 31 returns the page, zero-extended to 16 bits.
- R4: A write to registers 0 to 15 raises no bus request. It stores the 16-bit data together with the word address {page, register[3:0]}.
- R5: A write to register 16 raises exactly one bus write in that cycle. The address is {buffered page, buffered word, 2'b00} and the data is {wdata, buffered low half}. The page and word used are those buffered at the low-half write, even if the page changed afterwards.
- R6: A read of registers 0 to 15 raises one bus read in that cycle at address {page, register[3:0], 2'b00}. The next cycle it returns bits 15:0 of the read data, and it latches bits 31:16.
- R7: A read of register 16 raises no bus request. It returns the high half latched by the most recent low-half read.
- R8: Registers 17 to 30 at the bridge's PHY address are ignored. A write to them changes no state, and a read of them returns 0xFFFF.
- R9: `rsp_valid` is high in exactly the cycles that follow a read strobe, and it is never high after a write.
- R10: The low-half buffer persists after a bus write. A second high-half write with no new low-half write reuses the same low half and word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Decoded management access strobe, one per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_phy | input | 5 | PHY address of the access |
| acc_reg | input | 5 | Register number of the access |
| acc_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read answer valid, one cycle after a read strobe |
| rsp_data | output | 16 | Read answer |
| bus_req | output | 1 | Internal bus access this cycle |
| bus_we | output | 1 | Internal bus write when 1, read when 0 |
| bus_addr | output | 16 | Internal word address, bits 1:0 zero |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data, valid in the request cycle |

## Verification
The embedded assertions watch several rules on every cycle. Foreign PHY addresses and low-half writes never reach the bus. The read answer pulse follows read strobes exactly. Ignored registers answer all ones, and a high-half read leaves the latched upper half alone. Only the bench's behavioural model, compared every clock, can show the data relations. These are that a bus write combines the buffered word address and low half even after a later page change, that the upper half returned belongs to the last low-half read, and that buffered values survive repeated high-half writes and back-to-back strobes.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PAGE,
    ACC_LOW,
    ACC_HIGH,
    ACC_VOID
  } acc_kind_t;
endpackage

// File: rtl/mdio_acc_decode.sv
module mdio_acc_decode
  import mdio_bridge_pkg::*;
#(
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  parameter int IDX_W = 4,
  parameter logic [PHY_W-1:0] BRIDGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h1F,
  parameter logic [REG_W-1:0] HIGH_REG = 5'h10
) (
  input  logic             req,
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] regn,
  output acc_kind_t        kind
);
  localparam int WORDS = 1 << IDX_W;

  always_comb begin
    if (!req)                          kind = ACC_NONE;
    else if (phy != BRIDGE_PHY)        kind = ACC_VOID;
    else if (regn == PAGE_REG)         kind = ACC_PAGE;
    else if (int'(regn) < WORDS)       kind = ACC_LOW;
    else if (regn == HIGH_REG)         kind = ACC_HIGH;
    else                               kind = ACC_VOID;
  end
endmodule

// File: rtl/mdio_word_stage.sv
module mdio_word_stage
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int IDX_W  = 4,
  parameter int HALF_W = 16,
  localparam int WORD_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_t         kind,
  input  logic              wr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] rd_upper,
  output logic [PAGE_W-1:0] page_q,
  output logic [WORD_W-1:0] lo_word_q,
  output logic [HALF_W-1:0] lo_data_q,
  output logic [HALF_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      lo_word_q <= '0;
      lo_data_q <= '0;
      hi_q      <= '0;
    end else begin
      if (kind == ACC_PAGE && wr) page_q <= wdata[PAGE_W-1:0];
      if (kind == ACC_LOW && wr) begin
        lo_data_q <= wdata;
        lo_word_q <= {page_q, idx};
      end
      if (kind == ACC_LOW && !wr) hi_q <= rd_upper;
    end
  end

  // R7: a high-half read leaves the latched upper half alone
  a_r7_hi_kept: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_HIGH && !wr) |=> $stable(hi_q));

  // R8: ignored accesses touch no state
  a_r8_void_no_state: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_VOID) |=> ($stable(page_q) && $stable(lo_data_q) && $stable(lo_word_q) && $stable(hi_q)));
endmodule

// File: rtl/mdio_rsp_reg.sv
module mdio_rsp_reg
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_t         kind,
  input  logic              wr,
  input  logic [PAGE_W-1:0] page,
  input  logic [HALF_W-1:0] rd_lower,
  input  logic [HALF_W-1:0] hi,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data
);
  logic [HALF_W-1:0] sel;

  always_comb begin
    unique case (kind)
      ACC_PAGE: sel = HALF_W'(page);
      ACC_LOW:  sel = rd_lower;
      ACC_HIGH: sel = hi;
      default:  sel = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (kind != ACC_NONE) && !wr;
      if ((kind != ACC_NONE) && !wr) rsp_data <= sel;
    end
  end

  // R8 / R2: void reads are answered with all ones
  a_r8_void_ones: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_VOID && !wr) |=> (rsp_valid && rsp_data == '1));
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int PAGE_W = 10,
  parameter int IDX_W  = 4,
  parameter int HALF_W = 16,
  parameter logic [PHY_W-1:0] BRIDGE_PHY = 5'h1F,
  localparam int ADDR_W = PAGE_W + IDX_W + 2,
  localparam int WORD_W = PAGE_W + IDX_W,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic [PHY_W-1:0]  acc_phy,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic [HALF_W-1:0] acc_wdata,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  acc_kind_t         kind;
  logic [PAGE_W-1:0] page_q;
  logic [WORD_W-1:0] lo_word_q;
  logic [HALF_W-1:0] lo_data_q;
  logic [HALF_W-1:0] hi_q;

  mdio_acc_decode #(
    .PHY_W(PHY_W), .REG_W(REG_W), .IDX_W(IDX_W), .BRIDGE_PHY(BRIDGE_PHY),
    .PAGE_REG(REG_W'((1 << REG_W) - 1)), .HIGH_REG(REG_W'(1 << IDX_W))
  ) u_dec (
    .req(acc_req), .phy(acc_phy), .regn(acc_reg), .kind(kind)
  );

  mdio_word_stage #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .HALF_W(HALF_W)) u_stage (
    .clk(clk), .rst(rst), .kind(kind), .wr(acc_wr), .wdata(acc_wdata),
    .idx(acc_reg[IDX_W-1:0]), .rd_upper(bus_rdata[DATA_W-1:HALF_W]),
    .page_q(page_q), .lo_word_q(lo_word_q), .lo_data_q(lo_data_q), .hi_q(hi_q)
  );

  mdio_rsp_reg #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_rsp (
    .clk(clk), .rst(rst), .kind(kind), .wr(acc_wr), .page(page_q),
    .rd_lower(bus_rdata[HALF_W-1:0]), .hi(hi_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_comb begin
    bus_we    = (kind == ACC_HIGH) && acc_wr;
    bus_req   = bus_we || ((kind == ACC_LOW) && !acc_wr);
    bus_addr  = bus_we ? {lo_word_q, 2'b00} : {page_q, acc_reg[IDX_W-1:0], 2'b00};
    bus_wdata = {acc_wdata, lo_data_q};
  end

  // R2: a foreign PHY address never reaches the bus
  a_r2_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_phy != BRIDGE_PHY) |-> !bus_req);

  // R4: low-half writes are only buffered
  a_r4_low_write_held: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_wr && acc_phy == BRIDGE_PHY && int'(acc_reg) < (1 << IDX_W)) |-> !bus_req);

  // R9: the answer pulse follows read strobes exactly
  a_r9_rsp_tracks_read: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(acc_req && !acc_wr)));
endmodule

// File: tb/mdio_page_bridge_bench.sv
module mdio_page_bridge_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_req = 1'b0, acc_wr = 1'b0;
  logic [4:0] acc_phy = '0, acc_reg = '0;
  logic [15:0] acc_wdata = '0;
  logic rsp_valid, bus_req, bus_we;
  logic [15:0] rsp_data, bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] slave_val(input logic [15:0] a);
    return {a ^ 16'h5AC3, ~a};
  endfunction
  assign bus_rdata = slave_val(bus_addr);

  mdio_page_bridge u_mdio_page_bridge (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_wr(acc_wr), .acc_phy(acc_phy),
    .acc_reg(acc_reg), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // kinds: 0 none, 1 page, 2 low, 3 high, 4 ignored
  function automatic int kind_of(input logic r, input logic [4:0] p, input logic [4:0] g);
    if (!r) return 0;
    if (p != 5'h1F) return 4;
    if (g == 5'h1F) return 1;
    if (g < 16) return 2;
    if (g == 16) return 3;
    return 4;
  endfunction

  // behavioural reference state
  logic [9:0]  m_page = '0;
  logic [13:0] m_word = '0;
  logic [15:0] m_lo = '0, m_hi = '0;
  logic        m_rv = 1'b0;
  logic [15:0] m_rd = '0;
  string       m_tag = "R1";
  bit          fresh = 1;

  always @(posedge clk) begin
    int k;
    k = kind_of(acc_req, acc_phy, acc_reg);
    if (rst) begin
      m_page <= '0; m_word <= '0; m_lo <= '0; m_hi <= '0; m_rv <= 1'b0; fresh <= 1;
    end else begin
      m_rv <= (k != 0) && !acc_wr;
      if (k != 0 && !acc_wr) begin
        case (k)
          1: begin m_rd <= {6'd0, m_page}; m_tag <= fresh ? "R1" : "R3"; end
          2: begin m_rd <= slave_val({m_page, acc_reg[3:0], 2'b00}) & 32'hFFFF; m_tag <= "R6"; end
          3: begin m_rd <= m_hi; m_tag <= fresh ? "R1" : "R7"; end
          default: begin m_rd <= 16'hFFFF; m_tag <= (acc_phy != 5'h1F) ? "R2" : "R8"; end
        endcase
      end
      if (k == 1 && acc_wr) begin m_page <= acc_wdata[9:0]; fresh <= 0; end
      if (k == 2 && acc_wr) begin m_lo <= acc_wdata; m_word <= {m_page, acc_reg[3:0]}; end
      if (k == 2 && !acc_wr) begin m_hi <= slave_val({m_page, acc_reg[3:0], 2'b00}) >> 16; fresh <= 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, 2 ns before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      begin
        int k;
        logic erq, ewe;
        logic [15:0] ea;
        string t;
        k = kind_of(acc_req, acc_phy, acc_reg);
        chk(rsp_valid === m_rv, m_rv ? "R9" : (rst ? "R1" : "R9"), 32'(rsp_valid), 32'(m_rv));
        if (m_rv) chk(rsp_data === m_rd, m_tag, 32'(rsp_data), 32'(m_rd));
        ewe = (k == 3) && acc_wr;
        erq = ewe || ((k == 2) && !acc_wr);
        t = (k == 4) ? ((acc_phy != 5'h1F) ? "R2" : "R8") : (k == 2 && acc_wr) ? "R4" : ewe ? "R5" : "R6";
        chk(bus_req === erq, t, 32'(bus_req), 32'(erq));
        if (erq) begin
          ea = ewe ? {m_word, 2'b00} : {m_page, acc_reg[3:0], 2'b00};
          chk(bus_we === ewe, t, 32'(bus_we), 32'(ewe));
          chk(bus_addr === ea, t, 32'(bus_addr), 32'(ea));
          if (ewe) chk(bus_wdata === {acc_wdata, m_lo}, "R5", bus_wdata, {acc_wdata, m_lo});
        end
      end
    end
  end

  task automatic put(input logic w, input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = w; acc_phy = p; acc_reg = g; acc_wdata = d;
  endtask

  task automatic quiet();
    @(negedge clk);
    acc_req = 1'b0; acc_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values visible on the first reads
    put(0, 5'h1F, 5'h1F, 0); put(0, 5'h1F, 5'h10, 0); quiet();
    // R3 / R4 / R5: full write sequence
    put(1, 5'h1F, 5'h1F, 16'hFC2A); put(1, 5'h1F, 5'h05, 16'h1234); quiet();
    put(1, 5'h1F, 5'h10, 16'hABCD); quiet();
    put(0, 5'h1F, 5'h1F, 0); quiet();
    // R10: second high write reuses buffer
    put(1, 5'h1F, 5'h10, 16'h0F0F); quiet();
    // R5: page changes between halves
    put(1, 5'h1F, 5'h0A, 16'h5555); put(1, 5'h1F, 5'h1F, 16'h0033);
    put(1, 5'h1F, 5'h10, 16'h7777); quiet();
    // R6 / R7: read sequences over all words, back to back
    for (int i = 0; i < 16; i++) begin
      put(0, 5'h1F, 5'(i), 0); put(0, 5'h1F, 5'h10, 0);
    end
    quiet();
    // R2: foreign PHY write and read
    put(1, 5'h03, 5'h1F, 16'h02AA); put(1, 5'h00, 5'h10, 16'h1111);
    put(0, 5'h07, 5'h02, 0); put(0, 5'h1F, 5'h1F, 0); put(0, 5'h1F, 5'h10, 0); quiet();
    // R8: ignored registers
    for (int g = 17; g < 31; g++) begin
      put(1, 5'h1F, 5'(g), 16'hDEAD); put(0, 5'h1F, 5'(g), 0);
    end
    put(0, 5'h1F, 5'h1F, 0); put(0, 5'h1F, 5'h10, 0); put(1, 5'h1F, 5'h10, 16'h2222); quiet();
    // mixed sweep of pages and words
    for (int pg = 0; pg < 8; pg++) begin
      put(1, 5'h1F, 5'h1F, 16'(pg * 129));
      put(1, 5'h1F, 5'(pg * 2), 16'(pg * 4111));
      put(0, 5'h1F, 5'(15 - pg), 0);
      put(1, 5'h1F, 5'h10, 16'(~pg));
      put(0, 5'h1F, 5'h10, 0);
      quiet();
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule